// File: doc/BRIEF.md
# Device Status Flag Register

This block holds one 8-bit status word that gathers the condition flags of a small supervisory device into a single register on a simple register bus. Three kinds of bit share the word. Some copy live inputs every cycle. Some are derived from counters: a crystal qualifier counts oscillator edges, and an activity monitor keeps a sliding window of reference ticks. The rest are sticky and are cleared or restored by writing 1.

Software reads the word at its bus address to learn four things: whether the crystal may be trusted, where the comparator stands, whether the internal oscillator and the real-time clock kept their accuracy, and whether the sense pin has shown activity recently. The crystal clock and the sense pin arrive asynchronously and pass through two-flop synchronizers. The reference tick is a one-cycle enable pulse in the system clock domain. The supply-good levels, the event pulses and the live status inputs are taken as already synchronous to the system clock.

Top module: `status_flag_reg`

## Requirements
- R1: After reset the register reads 0x28 at address 0x32. A read at any other address returns 0x00.
- R2: Bit 7 becomes 1 only once 1024 rising edges of the crystal input have been counted, and stays 1 after that. It reads 0 while the count is below 1024 and whenever the force-internal input is high.
- R3: Bit 6 follows the comparator input and bit 4 follows the auto-detect input, each with one cycle of delay.
- R4: Bit 5 clears on an undervoltage event pulse and also in the cycle after bit 7's qualifier first becomes stable. Writing 1 to bit 5 sets it. A clearing event in the same cycle as that write wins.
- R5: Bit 3 sets in any cycle in which both supply-good inputs are low, and holds until a write of 1 to bit 3. When that condition and the write arrive in the same cycle, the bit stays set.
- R6: Bit 1 is 1 while an edge of either direction on the sense input lies within the last 32768 reference ticks. It returns to 0 on the 32768th tick after the last edge.
- R7: Bit 0 equals the lock input ANDed with the inverse of the spread-spectrum enable input.
- R8: Writing 0 to any bit has no effect. Writes to bits 7, 6, 4, 2, 1 and 0 are ignored, and so are writes at any address other than 0x32.
- R9: Read data is registered. It shows the register value, or 0x00, in the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| xtal_clk | input | 1 | Crystal oscillator clock, asynchronous |
| force_int_osc | input | 1 | Configuration: force the internal oscillator on |
| ref_tick | input | 1 | One-cycle enable pulse per reference-clock period |
| sense_in | input | 1 | Sense pin, asynchronous |
| osc_uv_evt | input | 1 | Pulse: internal oscillator supply undervoltage |
| vdd_ok | input | 1 | Main supply good |
| vbak_ok | input | 1 | Backup supply good |
| cmp_in | input | 1 | Comparator output (1 = reference above DAC level) |
| lock_in | input | 1 | Frequency loop lock indication |
| ss_en | input | 1 | Spread-spectrum enable |
| autodet_in | input | 1 | Auto-clock-detect state (1 = external clock active) |

## Verification
A wrong edge counter in the crystal qualifier shows up as bit 7 rising one edge early or late. Because bit 5 clears on the same event, the same fault is also visible on bit 5, four cycles after the deciding crystal edge reaches the pin. If the activity age counter is off, bit 1 drops one tick early or late around the 32768-tick boundary, so the bench brackets that boundary with reads one tick apart. Sticky bits with the wrong priority show up on the very next read after a write that coincides with a set or clear event. Every fault therefore reaches `rd_data` within one read of the cycle in which it happens.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int unsigned STAT_W = 8;

  // Bit positions decoded by software
  localparam int unsigned B_XTAL_OK  = 7;
  localparam int unsigned B_CMP      = 6;
  localparam int unsigned B_IOSC_OK  = 5;
  localparam int unsigned B_AUTODET  = 4;
  localparam int unsigned B_CLK_BAD  = 3;
  localparam int unsigned B_SENSE    = 1;
  localparam int unsigned B_LOCK     = 0;

  localparam logic [STAT_W-1:0] STAT_RESET = 8'h28;
  // Only these bits respond to a written 1
  localparam logic [STAT_W-1:0] WR1_MASK   = 8'h28;
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[i] <= 1'b0;
          else     sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/xtal_qualifier.sv
module xtal_qualifier #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_s,
  output logic stable
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = xtal_s & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      stable <= 1'b0;
    end else begin
      prev_q <= xtal_s;
      if (rise && !stable) begin
        if (cnt_q == LAST) stable <= 1'b1;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/activity_window.sv
module activity_window #(
  parameter int unsigned WINDOW = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_s,
  input  logic tick,
  output logic active
);
  localparam int unsigned AW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [AW-1:0] LAST = AW'(WINDOW - 1);

  logic          prev_q;
  logic [AW-1:0] age_q;
  logic          edge_seen;

  assign edge_seen = sense_s ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      age_q  <= '0;
      active <= 1'b0;
    end else begin
      prev_q <= sense_s;
      if (edge_seen) begin
        active <= 1'b1;
        age_q  <= '0;
      end else if (tick && active) begin
        if (age_q == LAST) active <= 1'b0;
        else               age_q  <= age_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR    = 8'h32,
  parameter int unsigned          XTAL_CYCLES = 1024,
  parameter int unsigned          WINDOW      = 32768,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              xtal_clk,
  input  logic              force_int_osc,
  input  logic              ref_tick,
  input  logic              sense_in,
  input  logic              osc_uv_evt,
  input  logic              vdd_ok,
  input  logic              vbak_ok,
  input  logic              cmp_in,
  input  logic              lock_in,
  input  logic              ss_en,
  input  logic              autodet_in
);
  logic              xtal_s, sense_s;
  logic              xtal_stable, xtal_stable_d;
  logic              sense_act;
  logic              hit;
  logic [STAT_W-1:0] wr1;
  logic [STAT_W-1:0] status_q;
  logic              iosc_clr, clk_bad_set;

  sync_ff #(.STAGES(SYNC_STAGES)) u_sync_xtal (
    .clk(clk), .rst(rst), .d(xtal_clk), .q(xtal_s)
  );

  sync_ff #(.STAGES(SYNC_STAGES)) u_sync_sense (
    .clk(clk), .rst(rst), .d(sense_in), .q(sense_s)
  );

  xtal_qualifier #(.CYCLES(XTAL_CYCLES)) u_xtal_q (
    .clk(clk), .rst(rst), .xtal_s(xtal_s), .stable(xtal_stable)
  );

  activity_window #(.WINDOW(WINDOW)) u_act (
    .clk(clk), .rst(rst), .sense_s(sense_s), .tick(ref_tick), .active(sense_act)
  );

  assign hit         = (addr == REG_ADDR);
  assign wr1         = (wr_en && hit) ? (wr_data & WR1_MASK) : '0;
  assign iosc_clr    = osc_uv_evt | (xtal_stable & ~xtal_stable_d);
  assign clk_bad_set = ~vdd_ok & ~vbak_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q      <= STAT_RESET;
      xtal_stable_d <= 1'b0;
    end else begin
      xtal_stable_d        <= xtal_stable;
      status_q[B_XTAL_OK]  <= xtal_stable & ~force_int_osc;
      status_q[B_CMP]      <= cmp_in;
      status_q[B_AUTODET]  <= autodet_in;
      status_q[2]          <= 1'b0;
      status_q[B_SENSE]    <= sense_act;
      status_q[B_LOCK]     <= lock_in & ~ss_en;
      // Sticky accuracy flag: events clear it, a written 1 restores it
      if (iosc_clr)             status_q[B_IOSC_OK] <= 1'b0;
      else if (wr1[B_IOSC_OK])  status_q[B_IOSC_OK] <= 1'b1;
      // Sticky fault flag: supply loss sets it, a written 1 clears it
      if (clk_bad_set)          status_q[B_CLK_BAD] <= 1'b1;
      else if (wr1[B_CLK_BAD])  status_q[B_CLK_BAD] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= hit ? status_q : '0;
  end
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic [7:0]        stat,
  input logic              force_int_osc,
  input logic              osc_uv_evt,
  input logic              vdd_ok,
  input logic              vbak_ok,
  input logic              cmp_in,
  input logic              lock_in,
  input logic              ss_en
);
  assert_reset_value_R1: assert property (@(posedge clk)
    $fell(rst) |-> stat == 8'h28);

  assert_read_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_ADDR) |=> rd_data == $past(stat));

  assert_read_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (addr != REG_ADDR) |=> rd_data == 8'h00);

  assert_force_masks_R2: assert property (@(posedge clk) disable iff (rst)
    force_int_osc |=> !stat[7]);

  assert_cmp_follow_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_in |=> stat[6]);

  assert_uv_clears_R4: assert property (@(posedge clk) disable iff (rst)
    osc_uv_evt |=> !stat[5]);

  assert_supply_loss_R5: assert property (@(posedge clk) disable iff (rst)
    (!vdd_ok && !vbak_ok) |=> stat[3]);

  assert_lock_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (ss_en || !lock_in) |=> !stat[0]);
endmodule

bind status_flag_reg status_flag_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .rd_data(rd_data), .stat(status_q),
  .force_int_osc(force_int_osc), .osc_uv_evt(osc_uv_evt), .vdd_ok(vdd_ok),
  .vbak_ok(vbak_ok), .cmp_in(cmp_in), .lock_in(lock_in), .ss_en(ss_en)
);

// File: tb/status_flag_reg_tb_top.sv
module status_flag_reg_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  REG_A  = 8'h32;
  localparam int unsigned WIN    = 32768;
  localparam int unsigned XCYC   = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic xtal_clk = 0, force_int_osc = 0, ref_tick = 0, sense_in = 0;
  logic osc_uv_evt = 0, vdd_ok = 1, vbak_ok = 1, cmp_in = 0;
  logic lock_in = 0, ss_en = 0, autodet_in = 0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit rd_req = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .xtal_clk(xtal_clk), .force_int_osc(force_int_osc),
    .ref_tick(ref_tick), .sense_in(sense_in), .osc_uv_evt(osc_uv_evt),
    .vdd_ok(vdd_ok), .vbak_ok(vbak_ok), .cmp_in(cmp_in), .lock_in(lock_in),
    .ss_en(ss_en), .autodet_in(autodet_in)
  );

  // Monitor: one registered result per read request
  always begin
    @(posedge clk);
    if (rd_req) begin
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: read with empty queue, actual %02h expected none", "R9", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    settle(4);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr   = a;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    addr   = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic xtal_edges(int n);
    repeat (n) begin
      @(negedge clk); xtal_clk = 1'b1;
      @(negedge clk); xtal_clk = 1'b0;
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); ref_tick = 1'b1;
    end
    @(negedge clk); ref_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    settle(4);
    rst = 1'b0;
    rd(REG_A, 8'h28, "R1 reset value R9");
    rd(8'h33, 8'h00, "R1 other address");

    wr(REG_A, 8'h00);
    rd(REG_A, 8'h28, "R8 write zero");
    wr(REG_A, 8'hFF);
    rd(REG_A, 8'h20, "R8 R5 write ones clears bit3 only");

    cmp_in = 1; autodet_in = 1;
    rd(REG_A, 8'h70, "R3 live bits high");
    cmp_in = 0; autodet_in = 0;
    rd(REG_A, 8'h20, "R3 live bits low");

    lock_in = 1;
    rd(REG_A, 8'h21, "R7 lock");
    ss_en = 1;
    rd(REG_A, 8'h20, "R7 spread masks lock");
    ss_en = 0; lock_in = 0;

    vdd_ok = 0;
    rd(REG_A, 8'h20, "R5 single supply low");
    @(negedge clk); vbak_ok = 0;
    @(negedge clk); vdd_ok = 1; vbak_ok = 1;
    rd(REG_A, 8'h28, "R5 both supplies low");
    wr(8'h31, 8'h08);
    rd(REG_A, 8'h28, "R8 other address write");
    @(negedge clk);
    addr = REG_A; wr_data = 8'h08; wr_en = 1; vdd_ok = 0; vbak_ok = 0;
    @(negedge clk);
    wr_en = 0; addr = '0; vdd_ok = 1; vbak_ok = 1;
    rd(REG_A, 8'h28, "R5 set beats clear");
    wr(REG_A, 8'h08);
    rd(REG_A, 8'h20, "R5 write one clears");

    @(negedge clk); osc_uv_evt = 1;
    @(negedge clk); osc_uv_evt = 0;
    rd(REG_A, 8'h00, "R4 undervoltage clears");
    wr(REG_A, 8'h20);
    rd(REG_A, 8'h20, "R4 write one restores");
    @(negedge clk);
    addr = REG_A; wr_data = 8'h20; wr_en = 1; osc_uv_evt = 1;
    @(negedge clk);
    wr_en = 0; addr = '0; osc_uv_evt = 0;
    rd(REG_A, 8'h00, "R4 event beats write");
    wr(REG_A, 8'h20);

    force_int_osc = 1;
    xtal_edges(XCYC - 1);
    rd(REG_A, 8'h20, "R2 one edge short");
    xtal_edges(1);
    rd(REG_A, 8'h00, "R2 forced low R4 cleared on stable");
    force_int_osc = 0;
    rd(REG_A, 8'h80, "R2 stable");
    wr(REG_A, 8'h20);
    rd(REG_A, 8'hA0, "R2 R4 restore after stable");

    @(negedge clk); sense_in = 1;
    rd(REG_A, 8'hA2, "R6 edge seen");
    ticks(WIN - 1);
    rd(REG_A, 8'hA2, "R6 last tick inside window");
    ticks(1);
    rd(REG_A, 8'hA0, "R6 window expired");

    settle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule